// File: doc/BRIEF.md
# Float Round-Toward-Zero Integral Unit

This block takes a single- or double-precision IEEE-754 operand and discards its fractional part. It always rounds toward zero and ignores any other rounding setting. The result stays in the operand's own floating-point format and has to fit the range of a signed 64-bit integer. An operand that cannot be represented in that range returns the encoding of -2^63 and raises the Invalid Operation flag. These operands are NaNs of either kind, infinities, and values whose truncation falls outside the range. A result that differs from its input raises the Inexact flag.

The result is written into the low element bits of a 128-bit destination word. The upper bits are either taken from the previous destination value or cleared, as selected by a merge input. A two-bit format code selects the element size. The codes with the upper bit set are reported as undefined encodings, and no result is produced for them. Every output is registered, so a result appears one clock after its inputs.

Top module: `fp_rtz_unit`

## Requirements
- R1: The result is the operand with its fractional part removed toward zero, so 2.7 gives 2.0 and -2.7 gives -2.0, in both formats.
- R2: Format code 2'b00 selects single precision, with the operand in src_i[31:0] and the result in res_o[31:0]. Format code 2'b01 selects double precision, using src_i[63:0] and res_o[63:0].
- R3: Format codes 2'b10 and 2'b11 set undef_o=1 and clear inexact_o and invalid_o. The whole dst_i value is then returned on res_o unchanged.
- R4: A zero of either sign returns the same zero with both flags clear.
- R5: inexact_o=1 exactly when a valid result differs numerically from the operand.
- R6: An infinity or a NaN, quiet or signalling, returns -2^63 with invalid_o=1 and inexact_o=0. The -2^63 encoding is 0xDF000000 in single precision and 0xC3E0000000000000 in double precision.
- R7: A truncated value of exactly -2^63 is returned unchanged with no flags. A positive value of 2^63 or more, or a negative value below -2^63, is handled as in R6.
- R8: A nonzero operand with magnitude below 1.0, subnormals included, returns a zero carrying the operand's sign and sets inexact_o=1.
- R9: An in-range operand whose unbiased exponent is at least the mantissa width (23 or 52) passes through unchanged with no flags.
- R10: With merge_i=1, the bits of res_o above the element come from dst_i. With merge_i=0 those bits are zero.
- R11: Outputs change one rising clock edge after their inputs are applied. While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Format code: 00 single, 01 double, 1x undefined |
| src_i | input | 64 | Operand; single precision uses the low 32 bits |
| dst_i | input | 128 | Prior destination value |
| merge_i | input | 1 | 1 keeps the upper destination bits, 0 clears them |
| res_o | output | 128 | Merged destination result |
| inexact_o | output | 1 | Inexact flag |
| invalid_o | output | 1 | Invalid Operation flag |
| undef_o | output | 1 | Undefined format code |

## Verification
The bench builds the block with its default parameters: a 128-bit destination and a 64-bit integer range. Both element sizes are therefore reachable, and so are the saturation limits at exactly ±2^63 in each format. With the 128-bit destination, a single-precision result leaves 96 upper bits for merging, and a double-precision result leaves 64. Directed cases cover both zeros, subnormals and the values on either side of each 2^63 limit. Further directed cases cover NaNs, infinities and the undefined codes. A run of random operands, partly steered toward exponents near the fraction boundary, is then checked against a reference that works on real numbers.

// File: rtl/fp_rtz_pkg.sv
package fp_rtz_pkg;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int DP_EXP_W = 11;
  localparam int DP_MAN_W = 52;
  localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;
  localparam int DP_W     = 1 + DP_EXP_W + DP_MAN_W;
  localparam int SP_BIAS  = (1 << (SP_EXP_W - 1)) - 1;
  localparam int DP_BIAS  = (1 << (DP_EXP_W - 1)) - 1;

  typedef enum logic [1:0] {
    FMT_SP = 2'b00,
    FMT_DP = 2'b01
  } fmt_e;
endpackage

// File: rtl/fp_rtz_trunc.sv
module fp_rtz_trunc #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 64
) (
  input  logic [EXP_W+MAN_W:0] op_i,
  output logic [EXP_W+MAN_W:0] res_o,
  output logic                 inexact_o,
  output logic                 invalid_o
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] E_ONE = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] E_INT = EXP_W'(BIAS + MAN_W);
  localparam logic [EXP_W-1:0] E_BIG = EXP_W'(BIAS + INT_W - 1);
  localparam logic [W-1:0] NMIN = {1'b1, E_BIG, {MAN_W{1'b0}}};

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic [EXP_W-1:0] sh;
  logic [MAN_W-1:0] frac_mask;

  assign sgn = op_i[W-1];
  assign ex  = op_i[W-2:MAN_W];
  assign mn  = op_i[MAN_W-1:0];

  always_comb begin
    res_o     = op_i;
    inexact_o = 1'b0;
    invalid_o = 1'b0;
    sh        = '0;
    frac_mask = '0;
    if (ex == '1) begin
      // inf / NaN saturate
      invalid_o = 1'b1;
      res_o     = NMIN;
    end else if (ex == '0 && mn == '0) begin
      res_o = op_i;
    end else if (ex < E_ONE) begin
      // |x| < 1, subnormals included
      res_o     = {sgn, {(W-1){1'b0}}};
      inexact_o = 1'b1;
    end else if (ex >= E_BIG) begin
      // only exact -2^63 survives
      if (!(sgn && ex == E_BIG && mn == '0)) begin
        invalid_o = 1'b1;
        res_o     = NMIN;
      end
    end else if (ex < E_INT) begin
      sh        = E_INT - ex;
      frac_mask = ~({MAN_W{1'b1}} << sh);
      inexact_o = |(mn & frac_mask);
      res_o     = {sgn, ex, mn & ~frac_mask};
    end
  end

  always_comb begin
    if (op_i[W-2:0] == '0)
      assert_zero_keep_R4: assert (res_o == op_i && !inexact_o && !invalid_o);
    if (ex != '1 && ex >= E_INT && ex < E_BIG)
      assert_integral_pass_R9: assert (res_o == op_i && !inexact_o && !invalid_o);
    if (ex != '1 && ex < E_ONE && op_i[W-2:0] != '0)
      assert_small_zero_R8: assert (res_o[W-2:0] == '0 && res_o[W-1] == sgn && inexact_o);
  end
endmodule

// File: rtl/fp_rtz_merge.sv
module fp_rtz_merge #(
  parameter int DST_W  = 128,
  parameter int ELEM_W = 32
) (
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [DST_W-1:0]  dst_i,
  input  logic              merge_i,
  output logic [DST_W-1:0]  dst_o
);
  localparam int UP_W = DST_W - ELEM_W;

  generate
    if (UP_W > 0) begin : g_upper
      assign dst_o = {merge_i ? dst_i[DST_W-1:ELEM_W] : {UP_W{1'b0}}, elem_i};
    end else begin : g_full
      assign dst_o = elem_i[DST_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fp_rtz_unit.sv
module fp_rtz_unit
  import fp_rtz_pkg::*;
#(
  parameter int DST_W = 128,
  parameter int INT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       fmt_i,
  input  logic [DP_W-1:0]  src_i,
  input  logic [DST_W-1:0] dst_i,
  input  logic             merge_i,
  output logic [DST_W-1:0] res_o,
  output logic             inexact_o,
  output logic             invalid_o,
  output logic             undef_o
);
  localparam logic [SP_W-1:0] SP_NMIN = {1'b1, SP_EXP_W'(SP_BIAS + INT_W - 1), {SP_MAN_W{1'b0}}};
  localparam logic [DP_W-1:0] DP_NMIN = {1'b1, DP_EXP_W'(DP_BIAS + INT_W - 1), {DP_MAN_W{1'b0}}};

  logic [SP_W-1:0]  sp_res;
  logic [DP_W-1:0]  dp_res;
  logic             sp_inx, sp_inv, dp_inx, dp_inv;
  logic [DST_W-1:0] sp_dst, dp_dst;
  logic [DST_W-1:0] res_d;
  logic             inx_d, inv_d, und_d;
  logic             dp_q, merge_q;

  fp_rtz_trunc #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W), .INT_W(INT_W)) u_sp_trunc (
    .op_i(src_i[SP_W-1:0]), .res_o(sp_res), .inexact_o(sp_inx), .invalid_o(sp_inv)
  );

  fp_rtz_trunc #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W), .INT_W(INT_W)) u_dp_trunc (
    .op_i(src_i), .res_o(dp_res), .inexact_o(dp_inx), .invalid_o(dp_inv)
  );

  fp_rtz_merge #(.DST_W(DST_W), .ELEM_W(SP_W)) u_sp_merge (
    .elem_i(sp_res), .dst_i(dst_i), .merge_i(merge_i), .dst_o(sp_dst)
  );

  fp_rtz_merge #(.DST_W(DST_W), .ELEM_W(DP_W)) u_dp_merge (
    .elem_i(dp_res), .dst_i(dst_i), .merge_i(merge_i), .dst_o(dp_dst)
  );

  always_comb begin
    unique case (fmt_i)
      FMT_SP: begin
        res_d = sp_dst; inx_d = sp_inx; inv_d = sp_inv; und_d = 1'b0;
      end
      FMT_DP: begin
        res_d = dp_dst; inx_d = dp_inx; inv_d = dp_inv; und_d = 1'b0;
      end
      default: begin
        // undefined code: destination untouched
        res_d = dst_i; inx_d = 1'b0; inv_d = 1'b0; und_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      inexact_o <= 1'b0;
      invalid_o <= 1'b0;
      undef_o   <= 1'b0;
      dp_q      <= 1'b0;
      merge_q   <= 1'b0;
    end else begin
      res_o     <= res_d;
      inexact_o <= inx_d;
      invalid_o <= inv_d;
      undef_o   <= und_d;
      dp_q      <= (fmt_i == FMT_DP);
      merge_q   <= merge_i;
    end
  end

  assert_flag_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !inexact_o);

  assert_sat_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (dp_q ? res_o[DP_W-1:0] == DP_NMIN : res_o[SP_W-1:0] == SP_NMIN));

  assert_undef_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (!invalid_o && !inexact_o));

  assert_clear_upper_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!merge_q && !undef_o) |-> (res_o[DST_W-1:DP_W] == '0 &&
                                (dp_q || res_o[DP_W-1:SP_W] == '0)));
endmodule

// File: tb/fp_rtz_unit_tb.sv
module fp_rtz_unit_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   fmt_i = 2'b00;
  logic [63:0]  src_i = '0;
  logic [127:0] dst_i = '0;
  logic         merge_i = 1'b0;
  logic [127:0] res_o;
  logic         inexact_o, invalid_o, undef_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  localparam real TWO63 = 9223372036854775808.0;
  localparam real TWO52 = 4503599627370496.0;

  always #10 clk_i = ~clk_i;

  fp_rtz_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fmt_i(fmt_i), .src_i(src_i), .dst_i(dst_i),
    .merge_i(merge_i), .res_o(res_o), .inexact_o(inexact_o), .invalid_o(invalid_o),
    .undef_o(undef_o)
  );

  function automatic real sp_to_real(input logic [31:0] b);
    logic [7:0]  e;
    logic [22:0] m;
    real r;
    e = b[30:23];
    m = b[22:0];
    if (e == 8'hFF) return $bitstoreal({b[31], 11'h7FF, m, 29'b0});
    if (e == 8'h00) begin
      r = real'(m);
      for (int i = 0; i < 149; i++) r = r / 2.0;
      return b[31] ? -r : r;
    end
    return $bitstoreal({b[31], 11'(int'(e) - 127 + 1023), m, 29'b0});
  endfunction

  function automatic logic [31:0] dp_to_sp(input logic [63:0] d);
    if (d[62:52] == '0) return {d[63], 31'b0};
    return {d[63], 8'(int'(d[62:52]) - 1023 + 127), d[51:29]};
  endfunction

  task automatic model(input logic [1:0] f, input logic [63:0] s, input logic [127:0] dst,
                       input logic mg, output logic [127:0] eres, output logic einx,
                       output logic einv, output logic eund);
    real x, t;
    longint li;
    logic [63:0] bits;
    logic sgn;
    eres = '0; einx = 0; einv = 0; eund = 0;
    if (f[1]) begin
      eres = dst; eund = 1;
      return;
    end
    x   = f[0] ? $bitstoreal(s) : sp_to_real(s[31:0]);
    sgn = f[0] ? s[63] : s[31];
    if ((x - x) != 0.0) begin
      einv = 1;
    end else begin
      if (x >= TWO52 || x <= -TWO52) t = x;
      else begin
        li = longint'(x);
        t  = real'(li);
        if (x >= 0.0 && t > x) t = t - 1.0;
        if (x < 0.0 && t < x) t = t + 1.0;
      end
      einv = (t >= TWO63) || (t < -TWO63);
      if (!einv) begin
        einx = (t != x);
        bits = (t == 0.0) ? {sgn, 63'b0} : $realtobits(t);
      end
    end
    if (einv) bits = 64'hC3E0000000000000;
    if (f[0]) eres = {mg ? dst[127:64] : 64'b0, bits};
    else      eres = {mg ? dst[127:32] : 96'b0, dp_to_sp(bits)};
  endtask

  task automatic apply(input logic [1:0] f, input logic [63:0] s, input logic [127:0] dst,
                       input logic mg, input string tag);
    logic [127:0] eres;
    logic einx, einv, eund;
    @(negedge clk_i);
    fmt_i = f; src_i = s; dst_i = dst; merge_i = mg;
    model(f, s, dst, mg, eres, einx, einv, eund);
    @(posedge clk_i);
    #1;
    n_checks++;
    if (res_o !== eres || inexact_o !== einx || invalid_o !== einv || undef_o !== eund) begin
      n_errors++;
      $display("FAIL %s fmt=%b src=%h: got res=%h inx=%b inv=%b und=%b exp res=%h inx=%b inv=%b und=%b",
               tag, f, s, res_o, inexact_o, invalid_o, undef_o, eres, einx, einv, eund);
    end
  endtask

  localparam logic [127:0] DST_PAT = 128'hA5A5_5A5A_1234_5678_9ABC_DEF0_0F0F_F0F0;

  initial begin
    #35;
    n_checks++;
    if (res_o !== '0 || inexact_o !== 0 || invalid_o !== 0 || undef_o !== 0) begin
      n_errors++;
      $display("FAIL R11 reset: got res=%h flags=%b%b%b exp all zero", res_o, inexact_o,
               invalid_o, undef_o);
    end
    rst_ni = 1'b1;

    // R1 R5 truncation, both formats
    apply(2'b01, 64'h4005_9999_9999_999A, DST_PAT, 1'b1, "R1 dp +2.7");
    apply(2'b01, 64'hC005_9999_9999_999A, DST_PAT, 1'b0, "R1 dp -2.7");
    apply(2'b00, 64'h0000_0000_402C_CCCD, DST_PAT, 1'b1, "R1 sp +2.7");
    apply(2'b00, 64'h0000_0000_C02C_CCCD, DST_PAT, 1'b0, "R2 sp -2.7");
    apply(2'b01, 64'h4024_0000_0000_0000, DST_PAT, 1'b0, "R5 dp exact 10.0");
    // R4 zeros
    apply(2'b01, 64'h0000_0000_0000_0000, DST_PAT, 1'b1, "R4 dp +0");
    apply(2'b01, 64'h8000_0000_0000_0000, DST_PAT, 1'b0, "R4 dp -0");
    apply(2'b00, 64'h0000_0000_8000_0000, DST_PAT, 1'b1, "R4 sp -0");
    // R8 small magnitudes
    apply(2'b01, 64'h3FE0_0000_0000_0000, DST_PAT, 1'b0, "R8 dp 0.5");
    apply(2'b01, 64'h8000_0000_0000_0001, DST_PAT, 1'b0, "R8 dp -subnormal");
    apply(2'b00, 64'h0000_0000_0000_0001, DST_PAT, 1'b1, "R8 sp subnormal");
    apply(2'b00, 64'h0000_0000_BF7F_FFFF, DST_PAT, 1'b0, "R8 sp -0.99");
    // R9 already integral
    apply(2'b01, 64'h4330_0000_0000_0001, DST_PAT, 1'b0, "R9 dp 2^52+1");
    apply(2'b00, 64'h0000_0000_4B00_0001, DST_PAT, 1'b0, "R9 sp 2^23+1");
    // R7 limits at 2^63
    apply(2'b01, 64'h43E0_0000_0000_0000, DST_PAT, 1'b0, "R7 dp +2^63");
    apply(2'b01, 64'hC3E0_0000_0000_0000, DST_PAT, 1'b0, "R7 dp -2^63");
    apply(2'b01, 64'hC3E0_0000_0000_0001, DST_PAT, 1'b0, "R7 dp below -2^63");
    apply(2'b01, 64'h43DF_FFFF_FFFF_FFFF, DST_PAT, 1'b0, "R7 dp below +2^63");
    apply(2'b00, 64'h0000_0000_5F00_0000, DST_PAT, 1'b1, "R7 sp +2^63");
    apply(2'b00, 64'h0000_0000_DF00_0000, DST_PAT, 1'b0, "R7 sp -2^63");
    apply(2'b00, 64'h0000_0000_DF00_0001, DST_PAT, 1'b0, "R7 sp below -2^63");
    // R6 specials
    apply(2'b01, 64'h7FF0_0000_0000_0000, DST_PAT, 1'b0, "R6 dp +inf");
    apply(2'b01, 64'hFFF0_0000_0000_0000, DST_PAT, 1'b1, "R6 dp -inf");
    apply(2'b01, 64'h7FF8_0000_0000_0000, DST_PAT, 1'b0, "R6 dp qnan");
    apply(2'b01, 64'h7FF0_0000_0000_0001, DST_PAT, 1'b0, "R6 dp snan");
    apply(2'b00, 64'h0000_0000_7FC0_0000, DST_PAT, 1'b1, "R6 sp qnan");
    apply(2'b00, 64'h0000_0000_FF80_0000, DST_PAT, 1'b0, "R6 sp -inf");
    // R3 undefined codes
    apply(2'b10, 64'h4005_9999_9999_999A, DST_PAT, 1'b0, "R3 code 10");
    apply(2'b11, 64'h7FF8_0000_0000_0000, ~DST_PAT, 1'b1, "R3 code 11");
    // R10 merge both sizes
    apply(2'b00, 64'hFFFF_FFFF_4120_0000, ~DST_PAT, 1'b1, "R10 sp merge");
    apply(2'b00, 64'hFFFF_FFFF_4120_0000, ~DST_PAT, 1'b0, "R10 sp clear");
    apply(2'b01, 64'h4120_0000_0000_0000, DST_PAT, 1'b1, "R10 dp merge");

    // R2 random operands, exponents steered near the fraction boundary
    for (int i = 0; i < 1500; i++) begin
      logic [63:0] s;
      logic [127:0] d;
      logic f0;
      s  = {$urandom, $urandom};
      d  = {$urandom, $urandom, $urandom, $urandom};
      f0 = i[0];
      if (i % 3 != 0) begin
        if (f0) s[62:52] = 11'(1000 + ($urandom % 100));
        else    s[30:23] = 8'(110 + ($urandom % 90));
      end
      apply({1'b0, f0}, s, d, i[1], "R2 random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL R11 watchdog: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule